// File: doc/BRIEF.md
# Interrupt Flag and Enable Register for a Bus Controller

This block is one 32-bit interrupt control word inside a bus controller. Software sees it through a simple register port. The upper half of the word holds eleven interrupt enables. The lower half holds the eleven matching flags, and every flag sits exactly 16 bit positions below its enable. A single interrupt line leaves the block.

The flags come in two kinds:
- **Sticky flags.** Six of them latch one-cycle event pulses from the protocol engine, the mode controller and the time-base counter. They stay set until software writes a 0 to them.
- **Live flags.** Five of them carry, without storage, the pending-condition levels that queues elsewhere in the controller supply.

Each of the four byte lanes can be written on its own. The interrupt line is a registered OR of every flag that has its enable set.

Top module: `ctl_irq_reg`

## Requirements
- R1: After a synchronous active-high reset, every stored bit is 0 and `irq` is 0. With all pending levels low, the read word is 0.
- R2: Enables are read/write at bits 31..26 and 20..16. Bits 25..21 and 9..5 always read 0, and writes to them are ignored.
- R3: A 1 on `evt_pulse[i]` sets the sticky flag at bit 2, 3, 12, 13, 14 or 15 for i = 0..5 respectively. The flag is visible on the read word one cycle later.
- R4: A write with a lane selected clears each sticky flag whose write-data bit is 0 in that lane. A write-data bit of 1 leaves the flag unchanged.
- R5: When a set pulse and a software clear hit the same sticky flag in one cycle, the flag ends up set.
- R6: Bits 0, 1, 4, 10 and 11 show `pend_lvl[0..4]` in the same cycle. Writes to these bits have no effect.
- R7: A write changes only the bytes whose `bus_be` bit is 1. `bus_be[k]` selects bits 8k+7..8k.
- R8: `irq` equals, one clock later, the OR over all eleven bit pairs of (flag AND the enable 16 positions above it).
- R9: `bus_rdata` is the register word combinationally while `bus_sel` is 1, and 0 while `bus_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register selected |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| evt_pulse | input | 6 | One-cycle set events for the sticky flags |
| pend_lvl | input | 5 | Pending levels shown by the live flags |
| irq | output | 1 | Registered combined interrupt |

## Verification
Directed cases come first:
- A full-width write of ones separates the implemented enable bits from the unimplemented holes.
- A single-lane write of zeros shows that lane selection isolates the enables from the flags.
- A pulse that coincides with a clear checks that the set wins.
- A write to the live bits while `pend_lvl` is high shows that they cannot be stored.

Random traffic then mixes sparse pulses, random lane masks, random data and changing levels. A bench model tracks the read word and the interrupt line one cycle behind. This exposes wrong set/clear priority, wrong lane decoding and wrong output latency.

// File: rtl/irq_reg_pkg.sv
`timescale 1ns/1ps
package irq_reg_pkg;
    localparam int REG_W    = 32;
    localparam int LANE_W   = 8;
    localparam int LANES    = REG_W / LANE_W;
    localparam int EN_OFS   = REG_W / 2;
    localparam int N_STICKY = 6;
    localparam int N_LIVE   = 5;

    typedef logic [REG_W-1:0] word_t;

    // flag positions; enable is EN_OFS above each
    localparam int STICKY_POS [N_STICKY] = '{2, 3, 12, 13, 14, 15};
    localparam int LIVE_POS   [N_LIVE]   = '{0, 1, 4, 10, 11};

    typedef struct packed {
        logic             sel;
        logic             we;
        logic [LANES-1:0] be;
        word_t            wdata;
    } bus_req_t;

    function automatic word_t flag_mask();
        word_t m = '0;
        for (int i = 0; i < N_STICKY; i++) m[STICKY_POS[i]] = 1'b1;
        for (int i = 0; i < N_LIVE; i++)   m[LIVE_POS[i]]   = 1'b1;
        return m;
    endfunction

    function automatic word_t en_mask();
        word_t f = flag_mask();
        word_t m = '0;
        for (int b = 0; b < EN_OFS; b++) m[b+EN_OFS] = f[b];
        return m;
    endfunction

    function automatic word_t impl_mask();
        return flag_mask() | en_mask();
    endfunction
endpackage

// File: rtl/irq_enable_bank.sv
`timescale 1ns/1ps
module irq_enable_bank
    import irq_reg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output word_t    en_q
);
    localparam word_t EN_M = en_mask();

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[l*LANE_W +: LANE_W] <= '0;
            end else if (req.sel && req.we && req.be[l]) begin
                en_q[l*LANE_W +: LANE_W] <= req.wdata[l*LANE_W +: LANE_W]
                                          & EN_M[l*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/irq_sticky_bank.sv
`timescale 1ns/1ps
module irq_sticky_bank
    import irq_reg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bus_req_t            req,
    input  logic [N_STICKY-1:0] evt_pulse,
    output logic [N_STICKY-1:0] flags_q
);
    for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
        localparam int POS  = STICKY_POS[i];
        localparam int LANE = POS / LANE_W;
        logic sw_clr;

        always_comb sw_clr = req.sel && req.we && req.be[LANE] && !req.wdata[POS];

        always_ff @(posedge clk) begin
            if (rst)               flags_q[i] <= 1'b0;
            else if (evt_pulse[i]) flags_q[i] <= 1'b1;   // set beats clear
            else if (sw_clr)       flags_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_merge.sv
`timescale 1ns/1ps
module irq_merge
    import irq_reg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  word_t               en_q,
    input  logic [N_STICKY-1:0] flags_q,
    input  logic [N_LIVE-1:0]   pend_lvl,
    output word_t               reg_word,
    output word_t               rdata,
    output logic                irq
);
    logic [EN_OFS-1:0] active;

    always_comb begin
        reg_word = en_q;
        for (int i = 0; i < N_STICKY; i++) reg_word[STICKY_POS[i]] = flags_q[i];
        for (int i = 0; i < N_LIVE; i++)   reg_word[LIVE_POS[i]]   = pend_lvl[i];
        active = reg_word[EN_OFS-1:0] & reg_word[REG_W-1:EN_OFS];
        rdata  = sel ? reg_word : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |active;
    end
endmodule

// File: rtl/ctl_irq_reg.sv
`timescale 1ns/1ps
module ctl_irq_reg
    import irq_reg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic [LANES-1:0]      bus_be,
    input  logic                  bus_we,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic [N_STICKY-1:0]   evt_pulse,
    input  logic [N_LIVE-1:0]     pend_lvl,
    output logic                  irq
);
    bus_req_t              req;
    word_t                 en_q;
    word_t                 reg_word;
    logic [N_STICKY-1:0]   flags_q;

    always_comb begin
        req.sel   = bus_sel;
        req.we    = bus_we;
        req.be    = bus_be;
        req.wdata = bus_wdata;
    end

    irq_enable_bank u_en (
        .clk(clk), .rst(rst), .req(req), .en_q(en_q)
    );

    irq_sticky_bank u_st (
        .clk(clk), .rst(rst), .req(req), .evt_pulse(evt_pulse), .flags_q(flags_q)
    );

    irq_merge u_mrg (
        .clk(clk), .rst(rst), .sel(bus_sel), .en_q(en_q), .flags_q(flags_q),
        .pend_lvl(pend_lvl), .reg_word(reg_word), .rdata(bus_rdata), .irq(irq)
    );
endmodule

// File: rtl/ctl_irq_reg_chk.sv
`timescale 1ns/1ps
module ctl_irq_reg_chk
    import irq_reg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [REG_W-1:0]    bus_rdata,
    input logic [N_STICKY-1:0] evt_pulse,
    input logic [N_LIVE-1:0]   pend_lvl,
    input logic [REG_W-1:0]    reg_word,
    input logic                irq
);
    localparam word_t IMPL = impl_mask();
    logic [N_STICKY-1:0] st_now;
    logic [N_LIVE-1:0]   live_now;

    always_comb begin
        for (int i = 0; i < N_STICKY; i++) st_now[i] = reg_word[STICKY_POS[i]];
        for (int i = 0; i < N_LIVE; i++)   live_now[i] = reg_word[LIVE_POS[i]];
    end

    assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_word & ~IMPL) == '0);

    assert_pulse_sets_R3: assert property (@(posedge clk) disable iff (rst)
        evt_pulse != '0 |=> (st_now & $past(evt_pulse)) == $past(evt_pulse));

    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_now & ~$past(st_now) & ~$past(evt_pulse)) == '0);

    assert_clear_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_we) |=> (~st_now & $past(st_now)) == '0);

    assert_live_tracks_R6: assert property (@(posedge clk) disable iff (rst)
        live_now == pend_lvl);

    assert_enable_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_we) |=> $stable(reg_word[REG_W-1:EN_OFS]));

    assert_irq_latency_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past(|(reg_word[EN_OFS-1:0] & reg_word[REG_W-1:EN_OFS])));

    assert_idle_read_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> bus_rdata == '0);
endmodule

bind ctl_irq_reg ctl_irq_reg_chk u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .pend_lvl(pend_lvl), .reg_word(reg_word), .irq(irq)
);

// File: tb/ctl_irq_reg_bench.sv
`timescale 1ns/1ps
module ctl_irq_reg_bench;
    localparam logic [31:0] EN_BITS = 32'hFC1F_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_pulse = '0;
    logic [4:0]  pend_lvl = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] en_m = '0;
    logic [31:0] st_m = '0;
    logic        exp_irq = 1'b0;

    always #2.5 clk = ~clk;

    ctl_irq_reg u_ctl_irq_reg (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_be(bus_be), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
        .pend_lvl(pend_lvl), .irq(irq)
    );

    function automatic logic [31:0] evt_img(logic [5:0] e);
        logic [31:0] w = '0;
        w[2] = e[0]; w[3] = e[1]; w[12] = e[2]; w[13] = e[3]; w[14] = e[4]; w[15] = e[5];
        return w;
    endfunction

    function automatic logic [31:0] live_img(logic [4:0] p);
        logic [31:0] w = '0;
        w[0] = p[0]; w[1] = p[1]; w[4] = p[2]; w[10] = p[3]; w[11] = p[4];
        return w;
    endfunction

    function automatic logic [31:0] lane_bits(logic [3:0] be);
        logic [31:0] m = '0;
        for (int k = 0; k < 4; k++) if (be[k]) m[k*8 +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check before the edge, update model at the edge
    task automatic cyc(input logic s, input logic w, input logic [3:0] be, input logic [31:0] d,
                       input logic [5:0] e, input logic [4:0] p, input string tag);
        logic [31:0] exp_rd, word, lm, clr;
        bus_sel = s; bus_we = w; bus_be = be; bus_wdata = d; evt_pulse = e; pend_lvl = p;
        #1;
        word   = en_m | st_m | live_img(p);
        exp_rd = s ? word : 32'h0;
        chk(bus_rdata === exp_rd, tag, bus_rdata, exp_rd);
        chk(irq === exp_irq, "R8 irq", {31'h0, irq}, {31'h0, exp_irq});
        @(posedge clk);
        exp_irq = |(word[15:0] & word[31:16]);
        if (s && w) begin
            lm   = lane_bits(be);
            en_m = (en_m & ~lm) | (d & lm & EN_BITS);
            clr  = lm & ~d & 32'h0000_F00C;
            st_m = st_m & ~clr;
        end
        st_m = st_m | evt_img(e);
        @(negedge clk);
    endtask

    task automatic peek(input logic [31:0] exp, input string tag);
        bus_sel = 1'b1; bus_we = 1'b0;
        #1;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        peek(32'h0, "R1 reset word");
        chk(irq === 1'b0, "R1 reset irq", {31'h0, irq}, 32'h0);

        cyc(1, 1, 4'hF, 32'hFFFF_FFFF, 6'h00, 5'h00, "R2 write ones");
        peek(32'hFC1F_0000, "R2 enables and holes");
        cyc(0, 0, 4'h0, 32'h0, 6'h3F, 5'h00, "R3 pulses");
        peek(32'hFC1F_F00C, "R3 sticky set");
        cyc(1, 1, 4'hF, 32'hFFFF_FFFF, 6'h00, 5'h00, "R4 write ones keep");
        peek(32'hFC1F_F00C, "R4 ones keep flags");
        cyc(1, 1, 4'b0010, 32'h0, 6'h00, 5'h00, "R7 lane one zero");
        peek(32'hFC1F_000C, "R7 only lane one cleared");
        cyc(1, 1, 4'b0010, 32'h0, 6'h20, 5'h00, "R5 set vs clear");
        peek(32'hFC1F_800C, "R5 set wins");
        cyc(1, 1, 4'b0011, 32'h0, 6'h00, 5'h1F, "R6 write live bits");
        peek(32'hFC1F_0C13, "R6 live bits unaffected");
        cyc(0, 0, 4'h0, 32'hFFFF_FFFF, 6'h00, 5'h1F, "R9 idle read zero");
        cyc(1, 1, 4'b1100, 32'h0, 6'h00, 5'h1F, "R8 mask all");
        cyc(1, 0, 4'h0, 32'h0, 6'h00, 5'h1F, "R8 masked");
        cyc(1, 0, 4'h0, 32'h0, 6'h00, 5'h1F, "R8 masked quiet");

        for (int n = 0; n < 3000; n++) begin
            logic [5:0] e;
            e = '0;
            for (int b = 0; b < 6; b++) e[b] = ($urandom % 8) == 0;
            cyc(($urandom % 4) != 0, ($urandom % 2) == 1, 4'($urandom), $urandom, e,
                5'($urandom), "R2/R3/R4/R5/R6/R7/R9 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule